// File: doc/BRIEF.md
# Accumulator ALU with Condition Code Register

This block is the arithmetic and flag core of a small accumulator-based processor. On each cycle with a valid operation it takes an operation code, two 8-bit operands and a 16-bit index value. It produces an 8-bit result, a 16-bit index result and the next value of an 8-bit condition code register that it holds itself. The outputs are registered and change on the clock edge that accepts the operation.

Each operation class has its own flag-update policy:
- Arithmetic sets all the arithmetic flags.
- Compare sets the same flags as subtract but does not write the result.
- Logic, load and store set N and Z and clear V.
- Shifts and rotates pass a bit through the carry so that multi-byte shifts can be chained.
- Index increment and decrement change only Z.
- Data-movement operations and the add-to-index operation leave every flag alone.

The interrupt mask bits and the stop-disable bit are only held here. A direct register write can change them, with one restriction: the X mask can be cleared this way but never set again.

Top module: `alu_ccr`

## Requirements
- R1: Operation codes on op_i are: 0 MOV, 1 ADD, 2 ADC, 3 SUB, 4 SBC, 5 CMP, 6 AND, 7 OR, 8 EOR, 9 LD, 10 ST, 11 ASL, 12 LSR, 13 ROL, 14 ROR, 15 ASR, 16 INX, 17 DEX, 18 ABX, 19 WCC. The ccr_o bits from bit 7 down to bit 0 are S, X, H, I, N, Z, V, C. After reset ccr_o is 8'hD0 (S, X and I set), and res_o and idx_o are 0.
- R2: ADD writes res_o = a_i + b_i, and ADC adds the old C as well. C is the carry out of bit 7, H is the carry out of bit 3, V is signed overflow, N is bit 7 of the result and Z is set when the result is zero.
- R3: SUB writes res_o = a_i - b_i, and SBC also subtracts the old C. C is the borrow, V is signed overflow, and N and Z follow the difference. H is unchanged.
- R4: CMP sets N, Z, V and C exactly as SUB would. res_o and H keep their values.
- R5: AND, OR and EOR write a_i op b_i. N and Z follow the result, V is cleared, and C and H are unchanged.
- R6: LD writes b_i and ST writes a_i to res_o. N and Z follow that value, V is cleared, and C and H are unchanged.
- R7: The shifts act on a_i, and the bit shifted out goes to C. ASL and LSR fill with 0. ROL and ROR fill with the old C. ASR keeps bit 7. N and Z follow the result, V = N xor C, and H is unchanged.
- R8: INX and DEX write idx_o = idx_i + 1 or idx_i - 1, modulo 2^16. Z is set when that 16-bit value is zero. All other ccr bits and res_o are unchanged.
- R9: MOV writes res_o = b_i. ABX writes idx_o = idx_i + b_i (b_i unsigned) and leaves res_o unchanged. Neither operation changes any ccr bit.
- R10: WCC loads ccr_o from b_i, except that X becomes old X AND b_i[6]. Once X is clear it stays clear until reset. res_o and idx_o are unchanged.
- R11: A cycle with op_valid_i low, or a valid cycle with an op code from 20 to 31, changes none of res_o, idx_o or ccr_o.
- R12: S, X and I change only through WCC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | An operation is present this cycle |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | Accumulator operand |
| b_i | input | 8 | Second operand / memory data |
| idx_i | input | 16 | Index register value |
| res_o | output | 8 | Registered 8-bit result |
| idx_o | output | 16 | Registered index result |
| ccr_o | output | 8 | Condition code register |

## Verification
Rotate through carry is the operation where two functions meet in one cycle. On the same edge it reads the carry left by the previous operation and writes a new carry of its own. The bench provokes this by issuing an add that carries out and then, on the very next cycle with no idle gap, a ROL or ROR. It also issues rotates back to back so that each one consumes the carry the previous one produced. The scoreboard model carries its own C from item to item, so a stale or early carry shows up as a wrong result bit and a wrong flag.

// File: rtl/alu_ccr_pkg.sv
package alu_ccr_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned IDX_W  = 16;
  localparam int unsigned CCR_W  = 8;
  localparam int unsigned OP_W   = 5;

  localparam int unsigned CCR_C = 0;
  localparam int unsigned CCR_V = 1;
  localparam int unsigned CCR_Z = 2;
  localparam int unsigned CCR_N = 3;
  localparam int unsigned CCR_I = 4;
  localparam int unsigned CCR_H = 5;
  localparam int unsigned CCR_X = 6;
  localparam int unsigned CCR_S = 7;

  localparam logic [CCR_W-1:0] CCR_RST = 8'hD0;

  typedef enum logic [OP_W-1:0] {
    OP_MOV = 5'd0,  OP_ADD = 5'd1,  OP_ADC = 5'd2,  OP_SUB = 5'd3,
    OP_SBC = 5'd4,  OP_CMP = 5'd5,  OP_AND = 5'd6,  OP_OR  = 5'd7,
    OP_EOR = 5'd8,  OP_LD  = 5'd9,  OP_ST  = 5'd10, OP_ASL = 5'd11,
    OP_LSR = 5'd12, OP_ROL = 5'd13, OP_ROR = 5'd14, OP_ASR = 5'd15,
    OP_INX = 5'd16, OP_DEX = 5'd17, OP_ABX = 5'd18, OP_WCC = 5'd19
  } op_e;

  typedef enum logic [2:0] {
    SH_ASL, SH_LSR, SH_ROL, SH_ROR, SH_ASR
  } shift_e;

  typedef enum logic [2:0] {
    CLS_NONE, CLS_ADD, CLS_SUB, CLS_LOGIC, CLS_SHIFT, CLS_INDEX, CLS_WCC
  } cls_e;

  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic v;
    logic c;
  } flag_set_t;

  function automatic cls_e op_class(logic [OP_W-1:0] op);
    case (op)
      OP_ADD, OP_ADC:                         return CLS_ADD;
      OP_SUB, OP_SBC, OP_CMP:                 return CLS_SUB;
      OP_AND, OP_OR, OP_EOR, OP_LD, OP_ST:    return CLS_LOGIC;
      OP_ASL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: return CLS_SHIFT;
      OP_INX, OP_DEX:                         return CLS_INDEX;
      OP_WCC:                                 return CLS_WCC;
      default:                                return CLS_NONE;
    endcase
  endfunction

  // which condition flags each class may touch
  function automatic flag_set_t flag_mask(cls_e cls);
    case (cls)
      CLS_ADD:   return '{h: 1'b1, n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b1};
      CLS_SUB:   return '{h: 1'b0, n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b1};
      CLS_LOGIC: return '{h: 1'b0, n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b0};
      CLS_SHIFT: return '{h: 1'b0, n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b1};
      CLS_INDEX: return '{h: 1'b0, n: 1'b0, z: 1'b1, v: 1'b0, c: 1'b0};
      default:   return '0;
    endcase
  endfunction

  function automatic logic writes_res(logic [OP_W-1:0] op);
    case (op)
      OP_MOV, OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_AND, OP_OR, OP_EOR,
      OP_LD, OP_ST, OP_ASL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic writes_idx(logic [OP_W-1:0] op);
    return (op == OP_INX) || (op == OP_DEX) || (op == OP_ABX);
  endfunction
endpackage

// File: rtl/alu_ccr_addsub.sv
module alu_ccr_addsub #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,   // carry for add, borrow for subtract
  output logic [W-1:0] sum_o,
  output logic         c_o,
  output logic         v_o,
  output logic         h_o
);
  localparam int unsigned NIB = 4;

  logic [W-1:0]   b_x;
  logic           ci;
  logic [W:0]     full;
  logic [W-1:0]   low;
  logic [NIB:0]   nib;

  always_comb begin
    b_x  = sub_i ? ~b_i : b_i;
    ci   = sub_i ? ~cin_i : cin_i;
    full = {1'b0, a_i} + {1'b0, b_x} + {{W{1'b0}}, ci};
    low  = {1'b0, a_i[W-2:0]} + {1'b0, b_x[W-2:0]} + {{(W-1){1'b0}}, ci};
    nib  = {1'b0, a_i[NIB-1:0]} + {1'b0, b_x[NIB-1:0]} + {{NIB{1'b0}}, ci};
    sum_o = full[W-1:0];
    c_o   = sub_i ? ~full[W] : full[W];
    v_o   = full[W] ^ low[W-1];
    h_o   = nib[NIB];
  end
endmodule

// File: rtl/alu_ccr_shift.sv
module alu_ccr_shift
  import alu_ccr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic         cin_i,
  input  shift_e       mode_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  always_comb begin
    res_o  = a_i;
    cout_o = 1'b0;
    case (mode_i)
      SH_ASL: begin res_o = {a_i[W-2:0], 1'b0};     cout_o = a_i[W-1]; end
      SH_LSR: begin res_o = {1'b0, a_i[W-1:1]};     cout_o = a_i[0];   end
      SH_ROL: begin res_o = {a_i[W-2:0], cin_i};    cout_o = a_i[W-1]; end
      SH_ROR: begin res_o = {cin_i, a_i[W-1:1]};    cout_o = a_i[0];   end
      SH_ASR: begin res_o = {a_i[W-1], a_i[W-1:1]}; cout_o = a_i[0];   end
      default: begin res_o = a_i; cout_o = cin_i; end
    endcase
  end
endmodule

// File: rtl/alu_ccr_flags.sv
module alu_ccr_flags
  import alu_ccr_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned IW = IDX_W
) (
  input  logic [OP_W-1:0]  op_i,
  input  logic [CCR_W-1:0] ccr_i,
  input  logic [DW-1:0]    val_i,
  input  logic [IW-1:0]    idx_val_i,
  input  logic [CCR_W-1:0] wr_data_i,
  input  logic             ar_c_i,
  input  logic             ar_v_i,
  input  logic             ar_h_i,
  input  logic             sh_c_i,
  output logic [CCR_W-1:0] ccr_o
);
  cls_e      cls;
  flag_set_t upd;
  flag_set_t nf;

  always_comb begin
    cls  = op_class(op_i);
    upd  = flag_mask(cls);
    nf   = '0;
    nf.n = val_i[DW-1];
    nf.z = ~|val_i;
    case (cls)
      CLS_ADD: begin
        nf.h = ar_h_i;
        nf.v = ar_v_i;
        nf.c = ar_c_i;
      end
      CLS_SUB: begin
        nf.v = ar_v_i;
        nf.c = ar_c_i;
      end
      CLS_SHIFT: begin
        nf.c = sh_c_i;
        nf.v = val_i[DW-1] ^ sh_c_i;
      end
      CLS_INDEX: nf.z = ~|idx_val_i;
      default: ;
    endcase
  end

  always_comb begin
    ccr_o = ccr_i;
    if (cls == CLS_WCC) begin
      ccr_o        = wr_data_i;
      ccr_o[CCR_X] = ccr_i[CCR_X] & wr_data_i[CCR_X];  // X may only fall
    end else begin
      ccr_o[CCR_H] = upd.h ? nf.h : ccr_i[CCR_H];
      ccr_o[CCR_N] = upd.n ? nf.n : ccr_i[CCR_N];
      ccr_o[CCR_Z] = upd.z ? nf.z : ccr_i[CCR_Z];
      ccr_o[CCR_V] = upd.v ? nf.v : ccr_i[CCR_V];
      ccr_o[CCR_C] = upd.c ? nf.c : ccr_i[CCR_C];
    end
  end
endmodule

// File: rtl/alu_ccr.sv
module alu_ccr
  import alu_ccr_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned IW = IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_valid_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [DW-1:0]    a_i,
  input  logic [DW-1:0]    b_i,
  input  logic [IW-1:0]    idx_i,
  output logic [DW-1:0]    res_o,
  output logic [IW-1:0]    idx_o,
  output logic [CCR_W-1:0] ccr_o
);
  logic [DW-1:0]    res_q;
  logic [IW-1:0]    idx_q;
  logic [CCR_W-1:0] ccr_q;
  logic [CCR_W-1:0] ccr_d;

  logic          ar_sub, ar_cin;
  logic [DW-1:0] ar_sum;
  logic          ar_c, ar_v, ar_h;
  shift_e        sh_mode;
  logic [DW-1:0] sh_res;
  logic          sh_c;
  logic [DW-1:0] val;
  logic [IW-1:0] idx_val;

  always_comb begin
    ar_sub = 1'b0;
    ar_cin = 1'b0;
    case (op_i)
      OP_ADC: ar_cin = ccr_q[CCR_C];
      OP_SUB, OP_CMP: ar_sub = 1'b1;
      OP_SBC: begin ar_sub = 1'b1; ar_cin = ccr_q[CCR_C]; end
      default: ;
    endcase
  end

  alu_ccr_addsub #(.W(DW)) i_addsub (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (ar_sub),
    .cin_i (ar_cin),
    .sum_o (ar_sum),
    .c_o   (ar_c),
    .v_o   (ar_v),
    .h_o   (ar_h)
  );

  always_comb begin
    case (op_i)
      OP_LSR:  sh_mode = SH_LSR;
      OP_ROL:  sh_mode = SH_ROL;
      OP_ROR:  sh_mode = SH_ROR;
      OP_ASR:  sh_mode = SH_ASR;
      default: sh_mode = SH_ASL;
    endcase
  end

  alu_ccr_shift #(.W(DW)) i_shift (
    .a_i    (a_i),
    .cin_i  (ccr_q[CCR_C]),
    .mode_i (sh_mode),
    .res_o  (sh_res),
    .cout_o (sh_c)
  );

  always_comb begin
    case (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP: val = ar_sum;
      OP_AND:                                 val = a_i & b_i;
      OP_OR:                                  val = a_i | b_i;
      OP_EOR:                                 val = a_i ^ b_i;
      OP_LD, OP_MOV:                          val = b_i;
      OP_ST:                                  val = a_i;
      OP_ASL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: val = sh_res;
      default:                                val = res_q;
    endcase
  end

  always_comb begin
    case (op_i)
      OP_INX:  idx_val = idx_i + {{(IW-1){1'b0}}, 1'b1};
      OP_DEX:  idx_val = idx_i - {{(IW-1){1'b0}}, 1'b1};
      OP_ABX:  idx_val = idx_i + {{(IW-DW){1'b0}}, b_i};
      default: idx_val = idx_q;
    endcase
  end

  alu_ccr_flags #(.DW(DW), .IW(IW)) i_flags (
    .op_i      (op_i),
    .ccr_i     (ccr_q),
    .val_i     (val),
    .idx_val_i (idx_val),
    .wr_data_i (b_i[CCR_W-1:0]),
    .ar_c_i    (ar_c),
    .ar_v_i    (ar_v),
    .ar_h_i    (ar_h),
    .sh_c_i    (sh_c),
    .ccr_o     (ccr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      idx_q <= '0;
      ccr_q <= CCR_RST;
    end else if (op_valid_i) begin
      if (writes_res(op_i)) res_q <= val;
      if (writes_idx(op_i)) idx_q <= idx_val;
      ccr_q <= ccr_d;
    end
  end

  assign res_o = res_q;
  assign idx_o = idx_q;
  assign ccr_o = ccr_q;
endmodule

// File: rtl/alu_ccr_chk.sv
module alu_ccr_chk
  import alu_ccr_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned IW = IDX_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             op_valid_i,
  input logic [OP_W-1:0]  op_i,
  input logic [DW-1:0]    res_o,
  input logic [IW-1:0]    idx_o,
  input logic [CCR_W-1:0] ccr_o
);
  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> $stable(res_o) && $stable(idx_o) && $stable(ccr_o));

  p_bad_op_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op_i > OP_WCC |=> $stable(res_o) && $stable(idx_o) && $stable(ccr_o));

  p_x_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ccr_o[CCR_X] |=> !ccr_o[CCR_X]);

  p_mask_keep_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op_i != OP_WCC |=>
      ccr_o[CCR_S] == $past(ccr_o[CCR_S]) && ccr_o[CCR_X] == $past(ccr_o[CCR_X]) &&
      ccr_o[CCR_I] == $past(ccr_o[CCR_I]));

  p_cmp_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op_i == OP_CMP |=> $stable(res_o) && ccr_o[CCR_H] == $past(ccr_o[CCR_H]));

  p_index_z_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && (op_i == OP_INX || op_i == OP_DEX) |=>
      ccr_o[7:3] == $past(ccr_o[7:3]) && ccr_o[1:0] == $past(ccr_o[1:0]) &&
      $stable(res_o) && ccr_o[CCR_Z] == (idx_o == '0));

  p_no_flags_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && (op_i == OP_MOV || op_i == OP_ABX) |=> $stable(ccr_o));

  p_ldst_v_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && (op_i == OP_LD || op_i == OP_ST) |=>
      !ccr_o[CCR_V] && ccr_o[CCR_C] == $past(ccr_o[CCR_C]) && ccr_o[CCR_Z] == (res_o == '0));

  p_logic_nz_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && (op_i == OP_AND || op_i == OP_OR || op_i == OP_EOR) |=>
      !ccr_o[CCR_V] && ccr_o[CCR_N] == res_o[DW-1] && ccr_o[CCR_Z] == (res_o == '0));

  p_shift_v_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op_i >= OP_ASL && op_i <= OP_ASR |=>
      ccr_o[CCR_V] == (ccr_o[CCR_N] ^ ccr_o[CCR_C]) && ccr_o[CCR_H] == $past(ccr_o[CCR_H]));
endmodule

bind alu_ccr alu_ccr_chk #(.DW(DW), .IW(IW)) i_alu_ccr_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_valid_i (op_valid_i),
  .op_i       (op_i),
  .res_o      (res_o),
  .idx_o      (idx_o),
  .ccr_o      (ccr_o)
);

// File: tb/test_alu_ccr.sv
`timescale 1ns/1ps
module test_alu_ccr;
  import alu_ccr_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [4:0]  op = '0;
  logic [7:0]  a = '0, b = '0;
  logic [15:0] idx = '0;
  logic [7:0]  res;
  logic [15:0] idx_out;
  logic [7:0]  ccr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0]  m_res = 8'h00;
  logic [15:0] m_idx = 16'h0000;
  logic [7:0]  m_ccr = 8'hD0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  alu_ccr i_alu_ccr (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .op_valid_i (op_valid),
    .op_i       (op),
    .a_i        (a),
    .b_i        (b),
    .idx_i      (idx),
    .res_o      (res),
    .idx_o      (idx_out),
    .ccr_o      (ccr)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual res/idx/ccr=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model, bit order S X H I N Z V C
  task automatic model(logic [4:0] o, logic [7:0] x, logic [7:0] y, logic [15:0] ix);
    logic [8:0]  t;
    logic [7:0]  r;
    logic        cf, vf, hf;
    logic [15:0] i2;
    cf = m_ccr[0];
    case (o)
      5'd1, 5'd2: begin
        t  = {1'b0, x} + {1'b0, y} + ((o == 5'd2) ? {8'd0, m_ccr[0]} : 9'd0);
        hf = ({1'b0, x[3:0]} + {1'b0, y[3:0]} + ((o == 5'd2) ? {4'd0, m_ccr[0]} : 5'd0)) > 5'd15;
        vf = (x[7] == y[7]) && (t[7] != x[7]);
        m_res = t[7:0];
        m_ccr[5] = hf; m_ccr[3] = t[7]; m_ccr[2] = (t[7:0] == 0);
        m_ccr[1] = vf; m_ccr[0] = t[8];
      end
      5'd3, 5'd4, 5'd5: begin
        t  = {1'b0, x} - {1'b0, y} - ((o == 5'd4) ? {8'd0, m_ccr[0]} : 9'd0);
        vf = (x[7] != y[7]) && (t[7] != x[7]);
        if (o != 5'd5) m_res = t[7:0];
        m_ccr[3] = t[7]; m_ccr[2] = (t[7:0] == 0); m_ccr[1] = vf; m_ccr[0] = t[8];
      end
      5'd6, 5'd7, 5'd8, 5'd9, 5'd10: begin
        case (o)
          5'd6: r = x & y;
          5'd7: r = x | y;
          5'd8: r = x ^ y;
          5'd9: r = y;
          default: r = x;
        endcase
        m_res = r;
        m_ccr[3] = r[7]; m_ccr[2] = (r == 0); m_ccr[1] = 1'b0;
      end
      5'd11, 5'd12, 5'd13, 5'd14, 5'd15: begin
        case (o)
          5'd11: begin r = x << 1;           cf = x[7]; end
          5'd12: begin r = x >> 1;           cf = x[0]; end
          5'd13: begin r = {x[6:0], m_ccr[0]}; cf = x[7]; end
          5'd14: begin r = {m_ccr[0], x[7:1]}; cf = x[0]; end
          default: begin r = {x[7], x[7:1]}; cf = x[0]; end
        endcase
        m_res = r;
        m_ccr[3] = r[7]; m_ccr[2] = (r == 0); m_ccr[1] = r[7] ^ cf; m_ccr[0] = cf;
      end
      5'd16, 5'd17: begin
        i2 = (o == 5'd16) ? ix + 16'd1 : ix - 16'd1;
        m_idx = i2;
        m_ccr[2] = (i2 == 0);
      end
      5'd18: m_idx = ix + {8'd0, y};
      5'd0:  m_res = y;
      5'd19: m_ccr = {y[7], y[6] & m_ccr[6], y[5:0]};
      default: ;
    endcase
  endtask

  // driver: applies one operation and queues its expected outcome
  task automatic issue(logic [4:0] o, logic [7:0] x, logic [7:0] y, logic [15:0] ix, string tag);
    @(negedge clk);
    op_valid = 1'b1; op = o; a = x; b = y; idx = ix;
    model(o, x, y, ix);
    exp_q.push_back({m_res, m_idx, m_ccr});
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      op_valid = 1'b0; op = 5'd1; a = 8'hFF; b = 8'hFF; idx = 16'hFFFF;
    end
  endtask

  // monitor: compares each accepted operation after its edge
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && op_valid) begin
        #3;
        if (exp_q.size() != 0) begin
          check(tag_q.pop_front(), {res, idx_out, ccr}, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state", {res, idx_out, ccr}, {8'h00, 16'h0000, 8'hD0});

    issue(5'd1, 8'h3A, 8'h48, 16'h0, "R2 add half carry and overflow");
    issue(5'd1, 8'hFF, 8'h01, 16'h0, "R2 add carry out to zero");
    issue(5'd2, 8'h10, 8'h20, 16'h0, "R2 adc uses carry");
    issue(5'd3, 8'h10, 8'h20, 16'h0, "R3 sub borrow");
    issue(5'd4, 8'h80, 8'h00, 16'h0, "R3 sbc borrow in, overflow");
    issue(5'd3, 8'h80, 8'h01, 16'h0, "R3 sub signed overflow");
    issue(5'd5, 8'h42, 8'h42, 16'h0, "R4 compare equal keeps result");
    issue(5'd5, 8'h01, 8'h02, 16'h0, "R4 compare borrow");
    issue(5'd6, 8'hF0, 8'h0F, 16'h0, "R5 and to zero");
    issue(5'd7, 8'h80, 8'h01, 16'h0, "R5 or negative");
    issue(5'd8, 8'hAA, 8'hAA, 16'h0, "R5 eor to zero");
    issue(5'd9, 8'h00, 8'h00, 16'h0, "R6 load zero");
    issue(5'd10, 8'h80, 8'h11, 16'h0, "R6 store negative");
    // carry produced by add, consumed by rotate on the next cycle
    issue(5'd1, 8'h80, 8'h80, 16'h0, "R2 add sets carry");
    issue(5'd13, 8'h40, 8'h00, 16'h0, "R7 rol takes carry");
    issue(5'd14, 8'h01, 8'h00, 16'h0, "R7 ror after rol");
    issue(5'd14, 8'h00, 8'h00, 16'h0, "R7 ror chained carry");
    issue(5'd11, 8'h81, 8'h00, 16'h0, "R7 asl");
    issue(5'd12, 8'h01, 8'h00, 16'h0, "R7 lsr to zero");
    issue(5'd15, 8'h83, 8'h00, 16'h0, "R7 asr keeps sign");
    issue(5'd16, 8'h00, 8'h00, 16'hFFFF, "R8 inx wraps to zero");
    issue(5'd16, 8'h00, 8'h00, 16'h1234, "R8 inx nonzero");
    issue(5'd17, 8'h00, 8'h00, 16'h0001, "R8 dex to zero");
    issue(5'd17, 8'h00, 8'h00, 16'h0000, "R8 dex wraps");
    issue(5'd18, 8'h00, 8'hFF, 16'hFF80, "R9 abx unsigned add");
    issue(5'd0, 8'h00, 8'h00, 16'h0, "R9 move zero leaves flags");
    issue(5'd19, 8'h00, 8'h2F, 16'h0, "R10 write ccr clears S X I");
    issue(5'd19, 8'h00, 8'hFF, 16'h0, "R10 X cannot be set again");
    issue(5'd1, 8'h7F, 8'h7F, 16'h0, "R12 add keeps mask bits");
    issue(5'd25, 8'h00, 8'h00, 16'h0, "R11 unknown code no change");
    idle(4);
    check("R11 idle cycles hold outputs", {res, idx_out, ccr}, {m_res, m_idx, m_ccr});

    issue(5'd19, 8'h00, 8'h00, 16'h0, "R10 write ccr to zero");
    issue(5'd13, 8'h80, 8'h00, 16'h0, "R7 rol carry clear in");
    issue(5'd13, 8'h00, 8'h00, 16'h0, "R7 rol chained carry in");
    idle(3);
    check("R12 mask bits after sequence", {24'h0, ccr & 8'hD0}, {24'h0, m_ccr & 8'hD0});

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule